// File: doc/BRIEF.md
# Background Debug Command Data Register

This block is the data-register side of a debug port that sits behind a JTAG TAP controller. When the instruction register selects the debug instruction, the host uses ordinary DR scans to talk to a small command engine while the CPU keeps running. A 10-bit scan register carries a 2-bit engine status in its low bits and an 8-bit data byte above it. An 8-bit holding register is the parallel side of that data byte. It buffers both what the host receives and what the host sends.

A host read takes two scans. The command scan shifts in an opcode. At Update-DR the engine copies the selected internal register (control or flags) into the holding register, and it pulses a read strobe toward that register. The follow-on scan captures the holding byte, so the value comes out on TDO. At the Update-DR of that second scan, the byte that was shifted in is discarded and the holding register returns to the no-operation value. While in-system programming owns the scan register, the engine ignores every update. In background operation the status field always reads 00.

The command engine has two states. ST_IDLE waits for a command. ST_RD_PEND waits for the follow-on data scan. The transitions are:
- IDLE_TO_PEND: a read opcode arrives at an accepted update.
- IDLE_STAY: any other opcode arrives at an accepted update.
- PEND_TO_IDLE: the next accepted update.

Top module: `dbg_bg_port`

## Requirements
- R1: The path acts only while `ir_code` equals 3'b010. With any other code, the scan register holds its value, `tdo_oe` stays low, updates change neither the holding register nor the engine state, and no read strobe fires.
- R2: On a TCK rising edge with `capture_dr` high, the scan register loads the holding byte into bits [9:2] and the status 2'b00 into bits [1:0]. In background operation the status is always 2'b00.
- R3: On a TCK rising edge with `shift_dr` high, the register shifts toward bit 0 and `tdi` enters bit 9. `tdo` takes bit 0 on the falling edge, so the two status bits come out first, then the data byte LSB first. `tdo_oe` is high exactly while selected and in Shift-DR.
- R4: While `trst_n` is low, the scan register, the holding register and `tdo` are zero, the engine is in ST_IDLE, and both strobes are low.
- R5: Opcode 8'h01 (bits [9:2] at Update-DR) in ST_IDLE does three things at the TCK falling edge: it copies `ctrl_reg_i` into the holding register, it moves the engine to ST_RD_PEND, and it raises `rd_ctrl_o` during that Update-DR.
- R6: Opcode 8'h02 in ST_IDLE does the same with `flag_reg_i` and raises `rd_flag_o`.
- R7: Opcode 8'h00, and every opcode other than 8'h01 and 8'h02, loads 8'h00 into the holding register, keeps the engine in ST_IDLE and fires no strobe.
- R8: In ST_RD_PEND, the next accepted update ignores the shifted-in byte, even a read opcode. It loads 8'h00, returns to ST_IDLE and fires no strobe.
- R9: When `isp_en` is 1 and `isp_mode` is 2'b00, programming owns the register. Updates then leave the holding register and the engine state unchanged and fire no strobe. With any other `isp_mode`, commands are accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| ir_code | input | 3 | Current instruction register value |
| capture_dr | input | 1 | TAP is in Capture-DR |
| shift_dr | input | 1 | TAP is in Shift-DR |
| update_dr | input | 1 | TAP is in Update-DR |
| tdi | input | 1 | Serial data from the host |
| isp_en | input | 1 | In-system programming enabled |
| isp_mode | input | 2 | Programming mode select |
| ctrl_reg_i | input | 8 | Control register contents |
| flag_reg_i | input | 8 | Flag register contents |
| tdo | output | 1 | Serial data to the host |
| tdo_oe | output | 1 | TDO drive enable |
| rd_ctrl_o | output | 1 | Control register read strobe |
| rd_flag_o | output | 1 | Flag register read strobe |

## Verification
The assertions check on every edge that capture loads the holding byte with a zero status and that each shift moves TDI into the top bit. They also check that TDO always mirrors bit 0, that the register freezes while deselected, and that the engine obeys its transitions: the read copies, the pending clear, the ignored updates under programming ownership, and strobes only during a selected Update-DR. Only the bench scenarios can show the two-scan read from the host side. That means the serial bit order of the returned word, the value reaching TDO one scan after the command, and a read opcode being swallowed as the data of a pending read. The scenarios also cover the recovery to normal operation after deselection and after programming ownership ends.

// File: rtl/dbg_bg_pkg.sv
package dbg_bg_pkg;

    localparam int DBG_DATA_W = 8;
    localparam int DBG_STAT_W = 2;

    localparam int OPC_NOP     = 0;
    localparam int OPC_RD_CTRL = 1;
    localparam int OPC_RD_FLAG = 2;

    localparam int STAT_BACKGROUND = 0;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_RD_PEND = 1'b1
    } eng_state_t;

endpackage

// File: rtl/dbg_bg_shreg.sv
module dbg_bg_shreg #(
    parameter int DATA_W = 8,
    parameter int STAT_W = 2
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              sel_i,
    input  logic              capture_i,
    input  logic              shift_i,
    input  logic              tdi_i,
    input  logic [DATA_W-1:0] par_i,
    input  logic [STAT_W-1:0] status_i,
    output logic [DATA_W-1:0] data_o,
    output logic              tdo_o
);

    localparam int SR_W = DATA_W + STAT_W;

    logic [SR_W-1:0] sr_q;

    // Capture and shift act on the rising edge of TCK.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            sr_q <= '0;
        end else if (sel_i) begin
            if (capture_i) begin
                sr_q <= {par_i, status_i};
            end else if (shift_i) begin
                sr_q <= {tdi_i, sr_q[SR_W-1:1]};
            end
        end
    end

    // TDO is launched on the falling edge, half a cycle ahead of the host sample.
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo_o <= 1'b0;
        end else begin
            tdo_o <= sr_q[0];
        end
    end

    assign data_o = sr_q[SR_W-1:STAT_W];

endmodule

// File: rtl/dbg_bg_engine.sv
module dbg_bg_engine
    import dbg_bg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              sel_i,
    input  logic              update_i,
    input  logic              isp_own_i,
    input  logic [DATA_W-1:0] cmd_i,
    input  logic [DATA_W-1:0] ctrl_i,
    input  logic [DATA_W-1:0] flag_i,
    output logic [DATA_W-1:0] hold_o,
    output logic              rd_ctrl_o,
    output logic              rd_flag_o
);

    localparam logic [DATA_W-1:0] CMD_NOP     = DATA_W'(OPC_NOP);
    localparam logic [DATA_W-1:0] CMD_RD_CTRL = DATA_W'(OPC_RD_CTRL);
    localparam logic [DATA_W-1:0] CMD_RD_FLAG = DATA_W'(OPC_RD_FLAG);

    eng_state_t        state_q, state_d;
    logic [DATA_W-1:0] hold_q, hold_d;
    logic              accept;

    assign accept = sel_i && update_i && !isp_own_i;

    // State register: the holding byte and the engine state change on the TCK falling edge.
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            state_q <= ST_IDLE;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            hold_q  <= hold_d;
        end
    end

    // Transitions and outputs.
    always_comb begin
        state_d   = state_q;
        hold_d    = hold_q;
        rd_ctrl_o = 1'b0;
        rd_flag_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (cmd_i == CMD_RD_CTRL) begin
                        hold_d    = ctrl_i;
                        rd_ctrl_o = 1'b1;
                        state_d   = ST_RD_PEND;
                    end else if (cmd_i == CMD_RD_FLAG) begin
                        hold_d    = flag_i;
                        rd_flag_o = 1'b1;
                        state_d   = ST_RD_PEND;
                    end else begin
                        hold_d = CMD_NOP;
                    end
                end
            end
            ST_RD_PEND: begin
                if (accept) begin
                    hold_d  = CMD_NOP;
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    assign hold_o = hold_q;

endmodule

// File: rtl/dbg_bg_port.sv
module dbg_bg_port
    import dbg_bg_pkg::*;
#(
    parameter int              DATA_W = DBG_DATA_W,
    parameter int              STAT_W = DBG_STAT_W,
    parameter int              IR_W   = 3,
    parameter logic [IR_W-1:0] DBG_IR = 3'b010,
    parameter int              MODE_W = 2
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic [IR_W-1:0]   ir_code,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              tdi,
    input  logic              isp_en,
    input  logic [MODE_W-1:0] isp_mode,
    input  logic [DATA_W-1:0] ctrl_reg_i,
    input  logic [DATA_W-1:0] flag_reg_i,
    output logic              tdo,
    output logic              tdo_oe,
    output logic              rd_ctrl_o,
    output logic              rd_flag_o
);

    localparam logic [STAT_W-1:0] BG_STATUS = STAT_W'(STAT_BACKGROUND);

    logic              dbg_sel;
    logic              isp_own;
    logic [DATA_W-1:0] cmd_byte;
    logic [DATA_W-1:0] hold_q;

    assign dbg_sel = (ir_code == DBG_IR);
    assign isp_own = isp_en && (isp_mode == '0);
    assign tdo_oe  = dbg_sel && shift_dr;

    dbg_bg_shreg #(
        .DATA_W (DATA_W),
        .STAT_W (STAT_W)
    ) u_shreg (
        .tck       (tck),
        .trst_n    (trst_n),
        .sel_i     (dbg_sel),
        .capture_i (capture_dr),
        .shift_i   (shift_dr),
        .tdi_i     (tdi),
        .par_i     (hold_q),
        .status_i  (BG_STATUS),
        .data_o    (cmd_byte),
        .tdo_o     (tdo)
    );

    dbg_bg_engine #(
        .DATA_W (DATA_W)
    ) u_eng (
        .tck       (tck),
        .trst_n    (trst_n),
        .sel_i     (dbg_sel),
        .update_i  (update_dr),
        .isp_own_i (isp_own),
        .cmd_i     (cmd_byte),
        .ctrl_i    (ctrl_reg_i),
        .flag_i    (flag_reg_i),
        .hold_o    (hold_q),
        .rd_ctrl_o (rd_ctrl_o),
        .rd_flag_o (rd_flag_o)
    );

endmodule

// File: rtl/dbg_bg_port_chk.sv
module dbg_bg_port_chk
    import dbg_bg_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int STAT_W = 2
) (
    input logic                     tck,
    input logic                     trst_n,
    input logic                     sel_i,
    input logic                     isp_own_i,
    input logic                     capture_dr,
    input logic                     shift_dr,
    input logic                     update_dr,
    input logic                     tdi,
    input logic [DATA_W-1:0]        ctrl_reg_i,
    input logic [DATA_W-1:0]        flag_reg_i,
    input logic                     tdo,
    input logic                     tdo_oe,
    input logic                     rd_ctrl_o,
    input logic                     rd_flag_o,
    input logic [DATA_W+STAT_W-1:0] sr_q,
    input logic [DATA_W-1:0]        hold_q,
    input eng_state_t               state_q
);

    localparam int                SR_W    = DATA_W + STAT_W;
    localparam logic [DATA_W-1:0] C_CTRL  = DATA_W'(OPC_RD_CTRL);
    localparam logic [DATA_W-1:0] C_FLAG  = DATA_W'(OPC_RD_FLAG);

    logic acc;
    assign acc = sel_i && update_dr && !isp_own_i;

    assert_frozen_unsel_R1: assert property (@(posedge tck) disable iff (!trst_n)
        $past(!sel_i) |-> $stable(sr_q));

    assert_oe_gate_R1: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe |-> (sel_i && shift_dr));

    assert_capture_R2: assert property (@(posedge tck) disable iff (!trst_n)
        $past(sel_i && capture_dr) |-> (sr_q == {$past(hold_q), {STAT_W{1'b0}}}));

    assert_shift_R3: assert property (@(posedge tck) disable iff (!trst_n)
        $past(sel_i && shift_dr && !capture_dr) |-> (sr_q == {$past(tdi), $past(sr_q[SR_W-1:1])}));

    assert_tdo_bit0_R3: assert property (@(posedge tck) disable iff (!trst_n)
        tdo == sr_q[0]);

    assert_rd_ctrl_R5: assert property (@(negedge tck) disable iff (!trst_n)
        $past(acc && state_q == ST_IDLE && sr_q[SR_W-1:STAT_W] == C_CTRL)
        |-> (state_q == ST_RD_PEND && hold_q == $past(ctrl_reg_i)));

    assert_strobe_window_R5: assert property (@(negedge tck) disable iff (!trst_n)
        (rd_ctrl_o || rd_flag_o) |-> (sel_i && update_dr && !(rd_ctrl_o && rd_flag_o)));

    assert_rd_flag_R6: assert property (@(negedge tck) disable iff (!trst_n)
        $past(acc && state_q == ST_IDLE && sr_q[SR_W-1:STAT_W] == C_FLAG)
        |-> (state_q == ST_RD_PEND && hold_q == $past(flag_reg_i)));

    assert_nop_R7: assert property (@(negedge tck) disable iff (!trst_n)
        $past(acc && state_q == ST_IDLE && sr_q[SR_W-1:STAT_W] != C_CTRL
              && sr_q[SR_W-1:STAT_W] != C_FLAG)
        |-> (state_q == ST_IDLE && hold_q == '0));

    assert_pend_clear_R8: assert property (@(negedge tck) disable iff (!trst_n)
        $past(acc && state_q == ST_RD_PEND) |-> (state_q == ST_IDLE && hold_q == '0));

    assert_isp_owns_R9: assert property (@(negedge tck) disable iff (!trst_n)
        $past(sel_i && update_dr && isp_own_i) |-> ($stable(hold_q) && $stable(state_q)));

endmodule

bind dbg_bg_port dbg_bg_port_chk #(
    .DATA_W (DATA_W),
    .STAT_W (STAT_W)
) u_chk (
    .tck        (tck),
    .trst_n     (trst_n),
    .sel_i      (dbg_sel),
    .isp_own_i  (isp_own),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .update_dr  (update_dr),
    .tdi        (tdi),
    .ctrl_reg_i (ctrl_reg_i),
    .flag_reg_i (flag_reg_i),
    .tdo        (tdo),
    .tdo_oe     (tdo_oe),
    .rd_ctrl_o  (rd_ctrl_o),
    .rd_flag_o  (rd_flag_o),
    .sr_q       (u_shreg.sr_q),
    .hold_q     (hold_q),
    .state_q    (u_eng.state_q)
);

// File: tb/dbg_bg_port_tb_top.sv
module dbg_bg_port_tb_top;

    localparam int CLK_PERIOD = 20;
    localparam int HALF       = CLK_PERIOD / 2;
    localparam int WDOG_CYC   = 100000;

    logic       tck = 1'b0;
    logic       trst_n;
    logic [2:0] ir_code;
    logic       capture_dr, shift_dr, update_dr, tdi;
    logic       isp_en;
    logic [1:0] isp_mode;
    logic [7:0] ctrl_reg_i, flag_reg_i;
    logic       tdo, tdo_oe, rd_ctrl_o, rd_flag_o;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 0;

    always #(HALF) tck = ~tck;

    dbg_bg_port dut_i (
        .tck        (tck),
        .trst_n     (trst_n),
        .ir_code    (ir_code),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .update_dr  (update_dr),
        .tdi        (tdi),
        .isp_en     (isp_en),
        .isp_mode   (isp_mode),
        .ctrl_reg_i (ctrl_reg_i),
        .flag_reg_i (flag_reg_i),
        .tdo        (tdo),
        .tdo_oe     (tdo_oe),
        .rd_ctrl_o  (rd_ctrl_o),
        .rd_flag_o  (rd_flag_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One full DR scan. Each TAP window starts 5 time units after a rising edge:
    // falling edge at +5, sample at +10, next rising edge at +15.
    task automatic scan(input logic [7:0] din, output logic [9:0] dout,
                        output int oe_cnt, output logic rdc, output logic rdf);
        logic [9:0] w;
        w      = {din, 2'b00};
        dout   = '0;
        oe_cnt = 0;
        capture_dr = 1'b1;
        #(CLK_PERIOD);
        capture_dr = 1'b0;
        for (int i = 0; i < 10; i++) begin
            shift_dr = 1'b1;
            tdi      = w[i];
            #(HALF);
            dout[i] = tdo;
            if (tdo_oe) oe_cnt++;
            #(HALF);
        end
        shift_dr  = 1'b0;
        tdi       = 1'b0;
        update_dr = 1'b1;
        #2;
        rdc = rd_ctrl_o;
        rdf = rd_flag_o;
        #(CLK_PERIOD - 2);
        update_dr = 1'b0;
        #(CLK_PERIOD);
    endtask

    task automatic t_reset;
        chk("R4", "tdo in reset", int'(tdo), 0);
        chk("R4", "tdo_oe in reset", int'(tdo_oe), 0);
        chk("R4", "strobes in reset", int'({rd_ctrl_o, rd_flag_o}), 0);
    endtask

    task automatic t_first_scan;
        logic [9:0] d; int oe; logic rc, rf;
        scan(8'h00, d, oe, rc, rf);
        chk("R4", "first capture returns zero", int'(d), 0);
        chk("R3", "tdo_oe count over shift", oe, 10);
        chk("R7", "nop strobes", int'({rc, rf}), 0);
    endtask

    task automatic t_read_ctrl;
        logic [9:0] d; int oe; logic rc, rf;
        ctrl_reg_i = 8'hA5;
        scan(8'h01, d, oe, rc, rf);
        chk("R5", "ctrl strobe on command", int'({rc, rf}), 2);
        scan(8'h3C, d, oe, rc, rf);
        chk("R5", "ctrl value on follow-on scan", int'(d), int'({8'hA5, 2'b00}));
        chk("R2", "status bits read 00", int'(d[1:0]), 0);
        chk("R8", "no strobe on data scan", int'({rc, rf}), 0);
        scan(8'h00, d, oe, rc, rf);
        chk("R8", "hold cleared after data scan", int'(d), 0);
    endtask

    task automatic t_read_flag;
        logic [9:0] d; int oe; logic rc, rf;
        flag_reg_i = 8'h5A;
        scan(8'h02, d, oe, rc, rf);
        chk("R6", "flag strobe on command", int'({rc, rf}), 1);
        scan(8'h01, d, oe, rc, rf);
        chk("R6", "flag value on follow-on scan", int'(d), int'({8'h5A, 2'b00}));
        chk("R8", "read opcode ignored while pending", int'({rc, rf}), 0);
        scan(8'h00, d, oe, rc, rf);
        chk("R8", "pending read opcode left hold at nop", int'(d), 0);
    endtask

    task automatic t_unsupported;
        logic [9:0] d; int oe; logic rc, rf;
        scan(8'h03, d, oe, rc, rf);
        chk("R7", "opcode 03 no strobe", int'({rc, rf}), 0);
        scan(8'hFF, d, oe, rc, rf);
        chk("R7", "opcode 03 leaves hold zero", int'(d), 0);
        chk("R7", "opcode FF no strobe", int'({rc, rf}), 0);
        scan(8'h02, d, oe, rc, rf);
        chk("R7", "engine still idle after unsupported", int'({rc, rf}), 1);
        scan(8'h00, d, oe, rc, rf);
        chk("R6", "flag returned after unsupported", int'(d), int'({8'h5A, 2'b00}));
    endtask

    task automatic t_deselect;
        logic [9:0] d; int oe; logic rc, rf;
        ctrl_reg_i = 8'hC3;
        scan(8'h01, d, oe, rc, rf);
        ir_code = 3'b011;
        scan(8'h00, d, oe, rc, rf);
        chk("R1", "tdo_oe low when deselected", oe, 0);
        chk("R1", "no strobe when deselected", int'({rc, rf}), 0);
        ir_code = 3'b010;
        scan(8'h00, d, oe, rc, rf);
        chk("R1", "hold kept across deselected scan", int'(d), int'({8'hC3, 2'b00}));
        scan(8'h00, d, oe, rc, rf);
        chk("R8", "pending cleared after reselect", int'(d), 0);
    endtask

    task automatic t_isp;
        logic [9:0] d; int oe; logic rc, rf;
        ctrl_reg_i = 8'h96;
        scan(8'h01, d, oe, rc, rf);
        isp_en = 1'b1; isp_mode = 2'b00;
        scan(8'h02, d, oe, rc, rf);
        chk("R9", "owned: no strobe", int'({rc, rf}), 0);
        chk("R9", "owned: capture still shows hold", int'(d), int'({8'h96, 2'b00}));
        isp_en = 1'b0;
        scan(8'h00, d, oe, rc, rf);
        chk("R9", "owned update left hold and pending", int'(d), int'({8'h96, 2'b00}));
        scan(8'h00, d, oe, rc, rf);
        chk("R9", "pending cleared after ownership ends", int'(d), 0);
        isp_en = 1'b1; isp_mode = 2'b01;
        flag_reg_i = 8'h81;
        scan(8'h02, d, oe, rc, rf);
        chk("R9", "nonzero mode accepts command", int'({rc, rf}), 1);
        scan(8'h00, d, oe, rc, rf);
        chk("R9", "nonzero mode returns flag", int'(d), int'({8'h81, 2'b00}));
        isp_en = 1'b0; isp_mode = 2'b00;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * WDOG_CYC);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog run did not complete actual=1 expected=0");
        finish_run();
    end

    initial begin
        trst_n     = 1'b0;
        ir_code    = 3'b010;
        capture_dr = 1'b0;
        shift_dr   = 1'b0;
        update_dr  = 1'b0;
        tdi        = 1'b0;
        isp_en     = 1'b0;
        isp_mode   = 2'b00;
        ctrl_reg_i = 8'h00;
        flag_reg_i = 8'h00;
        repeat (3) @(posedge tck);
        #5;
        t_reset();
        trst_n = 1'b1;
        #(CLK_PERIOD);
        t_first_scan();
        t_read_ctrl();
        t_read_flag();
        t_unsupported();
        t_deselect();
        t_isp();
        finish_run();
    end

endmodule